// File: doc/BRIEF.md
# Debug Serial Data Exchange Register

This block is a 32-bit word that two agents share: a processor on a register bus and an external debugger on a serial scan port. The processor sees the word as a high half and a low half of 16 bits each. It can write either half and read either half back. When the debug side selects the word and asserts shift, the word becomes a 32-stage shift chain. Each rising clock edge takes one serial bit in at the most significant end and moves every bit one place toward the least significant end. The serial output shows the least significant bit.

A typical exchange works as follows. The processor writes a message into both halves. The debugger shifts 32 bits through the chain, which reads that message out and leaves its own message behind. The processor then reads the debugger's message. No reset clears the word, so the data survives a reset of either side. The tap state machine, the instruction decode and the clock-domain crossing sit outside this block. Everything here runs on one clock.

Top module: `dbg_xchg_reg`

## Requirements
- R1: A CPU write stores `cpu_wdata` in the half chosen by `cpu_hi_sel` (1 = high half, word bits 31..16; 0 = low half, word bits 15..0) on the next rising edge, and the other half is unchanged.
- R2: `cpu_rdata` shows the half chosen by `cpu_hi_sel` combinationally, and reading has no side effect on the word.
- R3: When `scan_sel` and `scan_shift` are both high, each rising edge loads `tdi` into word bit 31 and moves word bits 31..1 into bits 30..0.
- R4: While `scan_sel` is high, `tdo` equals the current word bit 0. While `scan_sel` is low, `tdo` is 0.
- R5: After more than 32 shifts, the word holds the last 32 bits received, and the oldest of those sits at bit 0.
- R6: `scan_shift` has no effect while `scan_sel` is low.
- R7: When a CPU write and a shift occur in the same cycle, the addressed half takes `cpu_wdata` and the other half takes its shifted value.
- R8: While `rst` is high, the word keeps its contents. It is not cleared, and both writes and shifts are ignored.
- R9: With no write and no shift, the word holds its value across cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the bus and scan sides |
| rst | input | 1 | Synchronous active-high reset; freezes the word, never clears it |
| cpu_hi_sel | input | 1 | Half select: 1 = high half, 0 = low half |
| cpu_wr_en | input | 1 | Write strobe for the selected half |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data of the selected half |
| scan_sel | input | 1 | Debug path has this register selected |
| scan_shift | input | 1 | Shift-state enable from the tap controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (word bit 0 when selected, else 0) |

## Verification
Any wrong bit in the word becomes visible on `cpu_rdata` in the same cycle once the bench selects that half. On the serial side, a bit at position k reaches `tdo` after exactly k further shifts, so an ordering fault shows up within one 32-bit scan. A 40-bit scan over a known CPU-written word checks both directions together: `tdo` must replay the written word LSB first, and the readback must hold the final 32 serial bits. The collision, unselected-shift and reset-hold cases each use a readback in the cycle right after the stimulus, which catches any stray update before another write can hide it.

// File: rtl/dsx_pkg.sv
package dsx_pkg;

    localparam int DSX_HALF_W = 16;
    localparam int DSX_HALVES = 2;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } half_op_e;

    typedef struct packed {
        logic freeze;
        logic shift;
        logic wr;
        logic hi_sel;
    } xchg_ctl_t;

    // Bus load has priority over shifting; freeze beats everything.
    function automatic half_op_e pick_op(input logic freeze, input logic load,
                                         input logic shift);
        if (freeze)     return OP_HOLD;
        else if (load)  return OP_LOAD;
        else if (shift) return OP_SHIFT;
        else            return OP_HOLD;
    endfunction

    // Does a bus write with this half select address half number idx?
    function automatic logic half_hit(input logic hi_sel, input int idx);
        return (idx == DSX_HALVES - 1) ? hi_sel : !hi_sel;
    endfunction

endpackage

// File: rtl/dsx_half.sv
module dsx_half
    import dsx_pkg::*;
#(
    parameter int W = DSX_HALF_W
) (
    input  logic         clk,
    input  logic         freeze,
    input  logic         load,
    input  logic         shift,
    input  logic         shift_in,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] q
);

    half_op_e op;
    logic [W-1:0] q_r;

    always_comb op = pick_op(freeze, load, shift);

    // No reset term: contents survive every reset.
    always_ff @(posedge clk) begin
        case (op)
            OP_LOAD:  q_r <= load_data;
            OP_SHIFT: q_r <= {shift_in, q_r[W-1:1]};
            default:  q_r <= q_r;
        endcase
    end

    assign q = q_r;

    // R1 / R7: a bus load lands exactly.
    a_r1_load_lands: assert property (@(posedge clk) disable iff (freeze)
        load |=> q == $past(load_data));

    // R3: one shift step toward the LSB.
    a_r3_shift_step: assert property (@(posedge clk) disable iff (freeze)
        (shift && !load) |=> q == {$past(shift_in), $past(q[W-1:1])});

    // R9: idle halves hold.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (freeze)
        (!shift && !load) |=> $stable(q));

endmodule

// File: rtl/dsx_port.sv
module dsx_port
    import dsx_pkg::*;
#(
    parameter int HALF_W = DSX_HALF_W,
    localparam int WORD_W = DSX_HALVES * HALF_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic              hi_sel,
    input  logic              scan_sel,
    output logic [HALF_W-1:0] rdata,
    output logic              tdo
);

    always_comb begin
        rdata = hi_sel ? word[WORD_W-1 -: HALF_W] : word[HALF_W-1:0];
        tdo   = scan_sel & word[0];
    end

endmodule

// File: rtl/dbg_xchg_reg.sv
module dbg_xchg_reg
    import dsx_pkg::*;
#(
    parameter int HALF_W = DSX_HALF_W,
    localparam int NUM_HALVES = DSX_HALVES,
    localparam int WORD_W = NUM_HALVES * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_hi_sel,
    input  logic              cpu_wr_en,
    input  logic [HALF_W-1:0] cpu_wdata,
    output logic [HALF_W-1:0] cpu_rdata,
    input  logic              scan_sel,
    input  logic              scan_shift,
    input  logic              tdi,
    output logic              tdo
);

    xchg_ctl_t         ctl;
    logic [WORD_W-1:0] word;

    always_comb begin
        ctl.freeze = rst;
        ctl.shift  = scan_sel & scan_shift;
        ctl.wr     = cpu_wr_en;
        ctl.hi_sel = cpu_hi_sel;
    end

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        logic chain_in;
        logic [HALF_W-1:0] hq;

        if (g == NUM_HALVES - 1) begin : g_top
            assign chain_in = tdi;
        end else begin : g_link
            assign chain_in = word[(g+1)*HALF_W];
        end

        dsx_half #(.W(HALF_W)) u_half (
            .clk       (clk),
            .freeze    (ctl.freeze),
            .load      (ctl.wr & half_hit(ctl.hi_sel, g)),
            .shift     (ctl.shift),
            .shift_in  (chain_in),
            .load_data (cpu_wdata),
            .q         (hq)
        );

        assign word[g*HALF_W +: HALF_W] = hq;
    end

    dsx_port #(.HALF_W(HALF_W)) u_port (
        .word     (word),
        .hi_sel   (cpu_hi_sel),
        .scan_sel (scan_sel),
        .rdata    (cpu_rdata),
        .tdo      (tdo)
    );

    // R4: after a pure shift, tdo shows the bit that was one place up.
    a_r4_tdo_follows: assert property (@(posedge clk) disable iff (rst)
        (scan_sel && scan_shift && !cpu_wr_en) |=> (!scan_sel || tdo == $past(word[1])));

    // R6: unselected scan port never moves the word.
    a_r6_unselected_idle: assert property (@(posedge clk) disable iff (rst)
        (!scan_sel && !cpu_wr_en) |=> $stable(word));

    // R4: unselected port is quiet.
    a_r4_tdo_quiet: assert property (@(posedge clk) disable iff (rst)
        !scan_sel |-> !tdo);

endmodule

// File: tb/dbg_xchg_reg_tb.sv
module dbg_xchg_reg_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_hi_sel = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        scan_sel = 1'b0;
    logic        scan_shift = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbg_xchg_reg u_dut (
        .clk(clk), .rst(rst), .cpu_hi_sel(cpu_hi_sel), .cpu_wr_en(cpu_wr_en),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .scan_sel(scan_sel),
        .scan_shift(scan_shift), .tdi(tdi), .tdo(tdo)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic cpu_write(input logic hi, input logic [15:0] d);
        @(negedge clk);
        cpu_hi_sel = hi; cpu_wr_en = 1'b1; cpu_wdata = d;
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic read_word(output logic [31:0] w);
        @(negedge clk);
        cpu_hi_sel = 1'b1; #1 w[31:16] = cpu_rdata;
        cpu_hi_sel = 1'b0; #1 w[15:0]  = cpu_rdata;
    endtask

    task automatic load_word(input logic [31:0] w);
        cpu_write(1'b1, w[31:16]);
        cpu_write(1'b0, w[15:0]);
    endtask

    task automatic t_write_read();
        logic [31:0] w1, w2;
        load_word(32'hA5C3_1E7F);
        read_word(w1);
        chk("R1", w1, 32'hA5C3_1E7F);
        cpu_write(1'b0, 16'h0042);
        read_word(w1);
        chk("R1", w1, 32'hA5C3_0042);
        read_word(w2);
        chk("R2", w2, w1);
        repeat (5) @(negedge clk);
        read_word(w2);
        chk("R9", w2, 32'hA5C3_0042);
    endtask

    task automatic t_shift40();
        logic [31:0] w0, got;
        logic [39:0] pat;
        w0  = 32'h8BAD_F00D;
        pat = 40'h5A_3C96_E1F7;
        load_word(w0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            scan_sel = 1'b1; scan_shift = 1'b1; tdi = pat[i];
            #1;
            if (i < 32) chk("R4", {31'd0, tdo}, {31'd0, w0[i]});
            else        chk("R5", {31'd0, tdo}, {31'd0, pat[i-32]});
        end
        @(negedge clk);
        scan_shift = 1'b0;
        #1 chk("R4", {31'd0, tdo}, {31'd0, pat[8]});
        scan_sel = 1'b0;
        #1 chk("R4", {31'd0, tdo}, 32'd0);
        read_word(got);
        chk("R5", got, pat[39:8]);
    endtask

    task automatic t_single_shift();
        logic [31:0] got;
        load_word(32'h0000_0003);
        @(negedge clk);
        scan_sel = 1'b1; scan_shift = 1'b1; tdi = 1'b1;
        @(negedge clk);
        scan_shift = 1'b0; scan_sel = 1'b0;
        read_word(got);
        chk("R3", got, 32'h8000_0001);
    endtask

    task automatic t_unselected();
        logic [31:0] got;
        load_word(32'h1234_5679);
        @(negedge clk);
        scan_sel = 1'b0; scan_shift = 1'b1; tdi = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #1 chk("R4", {31'd0, tdo}, 32'd0);
            @(negedge clk);
        end
        scan_shift = 1'b0;
        read_word(got);
        chk("R6", got, 32'h1234_5679);
    endtask

    task automatic t_collide();
        logic [31:0] got;
        load_word(32'h0001_8000);
        @(negedge clk);
        scan_sel = 1'b1; scan_shift = 1'b1; tdi = 1'b0;
        cpu_hi_sel = 1'b1; cpu_wr_en = 1'b1; cpu_wdata = 16'hBEEF;
        @(negedge clk);
        cpu_wr_en = 1'b0; scan_shift = 1'b0; scan_sel = 1'b0;
        read_word(got);
        chk("R7", got, 32'hBEEF_C000);
        @(negedge clk);
        scan_sel = 1'b1; scan_shift = 1'b1; tdi = 1'b1;
        cpu_hi_sel = 1'b0; cpu_wr_en = 1'b1; cpu_wdata = 16'h0F0F;
        @(negedge clk);
        cpu_wr_en = 1'b0; scan_shift = 1'b0; scan_sel = 1'b0;
        read_word(got);
        chk("R7", got, 32'hDF77_0F0F);
    endtask

    task automatic t_reset_hold();
        logic [31:0] got;
        load_word(32'hC001_D00D);
        @(negedge clk);
        rst = 1'b1;
        cpu_hi_sel = 1'b1; cpu_wr_en = 1'b1; cpu_wdata = 16'h0000;
        scan_sel = 1'b1; scan_shift = 1'b1; tdi = 1'b0;
        repeat (4) @(negedge clk);
        cpu_wr_en = 1'b0; scan_shift = 1'b0; scan_sel = 1'b0;
        read_word(got);
        chk("R8", got, 32'hC001_D00D);
        @(negedge clk);
        rst = 1'b0;
        read_word(got);
        chk("R8", got, 32'hC001_D00D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 chk("R4", {31'd0, tdo}, 32'd0);
        rst = 1'b0;
        t_write_read();
        t_single_shift();
        t_shift40();
        t_unselected();
        t_collide();
        t_reset_hold();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule